// File: doc/BRIEF.md
# Iterative Tweakable Block Cipher Core

This block encrypts one 128-bit data block under a 128-bit key and a 128-bit tweak, computing one cipher round per clock. A start pulse captures the three inputs; the core then walks a two-level schedule of ten steps, each made of two rounds. Every round substitutes each byte through an 8-bit table, injects a 16-bit constant into the low half-word, and mixes each 32-bit column through a linear layer. The tweak key is refreshed and added to the state only at the end of each step.

The substitution, mixing, constant and tweak-key update functions are placeholders held in a package, so that the sequencing can be verified before the real tables are fitted. The core signals completion with a single-cycle done pulse and keeps the result on its output until the next block finishes.

Top module: `tbc_core`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and result_o is all zeros.
- R2: A start_i pulse is accepted only while busy_o is 0; a start_i seen while busy_o is 1 has no effect on the running block, its result or its timing.
- R3: When start_i is sampled at clock edge E0, busy_o is 1 from E0 to E20, and done_o and the result appear at edge E20 (20 rounds, one per clock).
- R4: done_o is high for exactly one cycle per accepted block.
- R5: result_o holds its value between completions; it changes only on the edge that raises done_o.
- R6: A round maps state x to L(S(x) XOR rc), where S applies to every byte b the map rotl1(b) XOR (b AND rotl2(b)) XOR 8'h5A, rc is XORed into bits [15:0], and L maps every 32-bit column c = state[32i+31:32i] to c XOR rotl7(c) XOR rotl19(c).
- R7: The constant for round r (0..1) of step s (0..9) is {8'(2s+r), s[3:0], 3'b101, r}, so it depends on both indices.
- R8: The tweak key is refreshed exactly once per step, after round 1: TK' = rotl8(TK) XOR (s+1) in the low byte, and the refreshed TK' is XORed into the state produced by that round.
- R9: At start the tweak key is TK0 = key XOR tweak and the state is loaded as data XOR TK0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a block (taken only when idle) |
| key_i | input | 128 | Cipher key |
| tweak_i | input | 128 | Tweak |
| data_i | input | 128 | Input block |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 128 | Output block, held until next completion |

## Verification
The only timed result is the completion: with start sampled at edge E0, done and the output are due at edge E20 and done must be low again after E21. The bench drives inputs on falling edges and counts falling edges after the start edge, sampling done low after 19, high after 20 and low after 21, and compares the output at that point against its own model of the step and round schedule. A second start issued mid-block must leave both the cycle count and the value unchanged, and the output is re-sampled over idle cycles to confirm it holds.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  localparam int BLK_W = 128;
  localparam int COL_W = 32;

  typedef logic [BLK_W-1:0] blk_t;

  // Placeholder 8-bit substitution
  function automatic logic [7:0] sub_byte(input logic [7:0] b);
    logic [7:0] r1, r2;
    r1 = {b[6:0], b[7]};
    r2 = {b[5:0], b[7:6]};
    return r1 ^ (b & r2) ^ 8'h5A;
  endfunction

  // Placeholder linear column mix
  function automatic logic [31:0] mix_col(input logic [31:0] c);
    return c ^ {c[24:0], c[31:25]} ^ {c[12:0], c[31:13]};
  endfunction

  // Round constant from step index and round index
  function automatic logic [15:0] round_const(input logic [7:0] stp, input logic rnd);
    logic [7:0] hi;
    hi = (stp << 1) + {7'd0, rnd};
    return {hi, stp[3:0], 3'b101, rnd};
  endfunction

  // Tweak-key refresh at a step boundary
  function automatic blk_t tk_refresh(input blk_t tk, input logic [7:0] stp);
    return {tk[BLK_W-9:0], tk[BLK_W-1:BLK_W-8]} ^ {{(BLK_W-8){1'b0}}, stp + 8'd1};
  endfunction

endpackage

// File: rtl/tbc_seq.sv
module tbc_seq #(
  parameter int STEPS    = 10,
  parameter int ROUNDS   = 2,
  localparam int SW      = (STEPS  > 1) ? $clog2(STEPS)  : 1,
  localparam int RW      = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          load,
  output logic          step_end,
  output logic          last_round,
  output logic [SW-1:0] stp,
  output logic [RW-1:0] rnd
);

  logic          busy_r;
  logic [SW-1:0] stp_r;
  logic [RW-1:0] rnd_r;

  assign busy       = busy_r;
  assign stp        = stp_r;
  assign rnd        = rnd_r;
  assign load       = start && !busy_r;
  assign step_end   = busy_r && (rnd_r == RW'(ROUNDS - 1));
  assign last_round = step_end && (stp_r == SW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      stp_r  <= '0;
      rnd_r  <= '0;
    end else if (load) begin
      busy_r <= 1'b1;
      stp_r  <= '0;
      rnd_r  <= '0;
    end else if (busy_r) begin
      if (step_end) begin
        rnd_r <= '0;
        if (last_round) begin
          busy_r <= 1'b0;
          stp_r  <= '0;
        end else begin
          stp_r <= stp_r + SW'(1);
        end
      end else begin
        rnd_r <= rnd_r + RW'(1);
      end
    end
  end

  // Counters stay inside their schedule ranges
  assert_counter_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stp_r <= SW'(STEPS - 1)) && (rnd_r <= RW'(ROUNDS - 1)));

  // A start during a block does not restart the counters
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && start && !step_end) |=> (rnd_r == $past(rnd_r) + RW'(1)) && $stable(stp_r));

  // The final round always ends the busy period
  assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> !busy_r);

endmodule

// File: rtl/tbc_round.sv
module tbc_round
  import tbc_pkg::*;
#(
  parameter int W = BLK_W,
  localparam int NBYTE = W / 8,
  localparam int NCOL  = W / COL_W
) (
  input  logic [W-1:0] st_i,
  input  logic [15:0]  rc_i,
  output logic [W-1:0] st_o
);

  logic [W-1:0] sub_w;
  logic [W-1:0] add_w;

  for (genvar b = 0; b < NBYTE; b++) begin : g_sbox
    assign sub_w[8*b +: 8] = sub_byte(st_i[8*b +: 8]);
  end

  assign add_w = sub_w ^ {{(W-16){1'b0}}, rc_i};

  for (genvar c = 0; c < NCOL; c++) begin : g_mix
    assign st_o[COL_W*c +: COL_W] = mix_col(add_w[COL_W*c +: COL_W]);
  end

endmodule

// File: rtl/tbc_core.sv
module tbc_core
  import tbc_pkg::*;
#(
  parameter int STEPS  = 10,
  parameter int ROUNDS = 2,
  localparam int SW    = (STEPS  > 1) ? $clog2(STEPS)  : 1,
  localparam int RW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [127:0] key_i,
  input  logic [127:0] tweak_i,
  input  logic [127:0] data_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [127:0] result_o
);

  logic          load, step_end, last_round, busy;
  logic [SW-1:0] stp;
  logic [RW-1:0] rnd;

  blk_t          state_r, tk_r, result_r;
  logic          done_r;
  blk_t          round_out, tk_next, step_out;
  logic [15:0]   rc;

  tbc_seq #(.STEPS(STEPS), .ROUNDS(ROUNDS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start_i),
    .busy(busy), .load(load), .step_end(step_end), .last_round(last_round),
    .stp(stp), .rnd(rnd)
  );

  assign rc = round_const(8'(stp), rnd[0]);

  tbc_round #(.W(BLK_W)) round_i (
    .st_i(state_r), .rc_i(rc), .st_o(round_out)
  );

  assign tk_next  = tk_refresh(tk_r, 8'(stp));
  assign step_out = round_out ^ tk_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r  <= '0;
      tk_r     <= '0;
      result_r <= '0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (load) begin
        tk_r    <= key_i ^ tweak_i;
        state_r <= data_i ^ key_i ^ tweak_i;
      end else if (busy) begin
        if (step_end) begin
          tk_r    <= tk_next;
          state_r <= step_out;
          if (last_round) begin
            result_r <= step_out;
            done_r   <= 1'b1;
          end
        end else begin
          state_r <= round_out;
        end
      end
    end
  end

  assign busy_o   = busy;
  assign done_o   = done_r;
  assign result_o = result_r;

  // Tweak key is held inside a step
  assert_tk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_end) |=> $stable(tk_r));

  // Done follows the last round
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> done_r);

  // Done is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |=> !done_r);

  // Result changes only together with done
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_r |-> $stable(result_r));

  // Start while busy leaves the tweak key untouched inside a step
  assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !step_end) |=> $stable(tk_r));

endmodule

// File: tb/tbc_core_tb.sv
module tbc_core_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0, tweak_i = '0, data_i = '0;
  logic         busy_o, done_o;
  logic [127:0] result_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tbc_core dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .key_i(key_i), .tweak_i(tweak_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // ---- independent model ----
  function automatic logic [7:0] m_sub(input logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++)
      y[i] = x[(i + 7) % 8] ^ (x[i] & x[(i + 6) % 8]);
    return y ^ 8'b0101_1010;
  endfunction

  function automatic logic [31:0] m_rotl32(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [127:0] m_round(input logic [127:0] x, input int s, input int r);
    logic [127:0] y;
    logic [15:0]  k;
    for (int b = 0; b < 16; b++) y[8*b +: 8] = m_sub(x[8*b +: 8]);
    k = {8'(s * 2 + r), 4'(s), 3'd5, 1'(r)};
    y[15:0] = y[15:0] ^ k;
    for (int c = 0; c < 4; c++)
      y[32*c +: 32] = y[32*c +: 32] ^ m_rotl32(y[32*c +: 32], 7) ^ m_rotl32(y[32*c +: 32], 19);
    return y;
  endfunction

  function automatic logic [127:0] m_cipher(input logic [127:0] k, input logic [127:0] t,
                                            input logic [127:0] d);
    logic [127:0] tk, st;
    tk = k ^ t;
    st = d ^ tk;
    for (int s = 0; s < 10; s++) begin
      for (int r = 0; r < 2; r++) begin
        st = m_round(st, s, r);
        if (r == 1) begin
          tk = (tk << 8) | (tk >> 120);
          tk[7:0] = tk[7:0] ^ 8'(s + 1);
          st = st ^ tk;
        end
      end
    end
    return st;
  endfunction

  task automatic check(input string req, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Start a block; returns after the start edge, at the following falling edge
  task automatic pulse_start(input logic [127:0] k, input logic [127:0] t, input logic [127:0] d);
    @(negedge clk);
    key_i = k; tweak_i = t; data_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Run a block and check timing and value
  task automatic run_block(input string tag, input logic [127:0] k, input logic [127:0] t,
                           input logic [127:0] d, input bit poke_mid);
    logic [127:0] exp;
    exp = m_cipher(k, t, d);
    pulse_start(k, t, d);
    check("R3", {tag, " busy after start"}, 128'(busy_o), 128'(1));
    for (int n = 1; n <= 19; n++) begin
      if (poke_mid && n == 6) begin
        start_i = 1'b1; data_i = ~d; key_i = ~k;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    check("R3", {tag, " done not early"}, 128'(done_o), 128'(0));
    @(negedge clk);
    check("R3", {tag, " done at round 20"}, 128'(done_o), 128'(1));
    check("R6", {tag, " result value"}, result_o, exp);
    check("R3", {tag, " busy cleared"}, 128'(busy_o), 128'(0));
    @(negedge clk);
    check("R4", {tag, " done single cycle"}, 128'(done_o), 128'(0));
  endtask

  task automatic t_reset;
    check("R1", "busy at reset", 128'(busy_o), 128'(0));
    check("R1", "done at reset", 128'(done_o), 128'(0));
    check("R1", "result at reset", result_o, '0);
  endtask

  task automatic t_zero_block;
    // all-zero inputs still give a nonzero result via constants R7 and refresh R8
    run_block("zero", '0, '0, '0, 1'b0);
  endtask

  task automatic t_patterns;
    run_block("p1", 128'h000102030405060708090a0b0c0d0e0f,
              128'hffeeddccbbaa99887766554433221100,
              128'h0123456789abcdef0f1e2d3c4b5a6978, 1'b0);
    run_block("p2", {4{32'hdeadbeef}}, '0, {16{8'h80}}, 1'b0);
    // tweak alone changes the result (R9)
    run_block("p3", {4{32'hdeadbeef}}, 128'h1, {16{8'h80}}, 1'b0);
  endtask

  task automatic t_start_busy;
    run_block("busy-start R2", 128'h1111, 128'h2222, 128'h3333, 1'b1);
  endtask

  task automatic t_hold;
    logic [127:0] held;
    held = result_o;
    for (int n = 0; n < 8; n++) @(negedge clk);
    check("R5", "result held idle", result_o, held);
    data_i = ~data_i;
    @(negedge clk);
    check("R5", "result held after input change", result_o, held);
    pulse_start(128'h5, 128'h6, 128'h7);
    for (int n = 1; n <= 10; n++) @(negedge clk);
    check("R5", "result held mid-block", result_o, held);
    for (int n = 11; n <= 20; n++) @(negedge clk);
    check("R5", "result updated at done", result_o, m_cipher(128'h5, 128'h6, 128'h7));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_block();
    t_patterns();
    t_start_busy();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule